// File: doc/BRIEF.md
# Halfword Packing Buffer with Parked Write Address

The block takes a stream of 16-bit halfwords, one per clock, each marked by a valid flag. It joins each two back-to-back halfwords into a 32-bit word and queues the words in a 128-entry memory, which a consumer drains in order through a read request and a registered read port. The earlier halfword of a pair fills the upper half of the word.

The memory is written on every clock, with no write-enable gating. When no complete word is ready, the write lands at the parked address, which is the slot the write pointer names and which holds no unread data. The pointer moves past that slot only when a real word has been written there. The halfword pair passes through two registers before it reaches the memory data input. Address and data reach the memory straight from registers. Read data passes through one extra register after the memory's own output register.

Top module: `hwpack_buf`

## Requirements
- R1: After reset `bufEmpty` is 1, `bufFull` is 0, `rdValid` is 0 and `rdData` is zero.
- R2: Two halfwords with `inValid` high on consecutive clocks form one word: the first one in bits 31:16, the second in bits 15:0.
- R3: If `inValid` goes low after an odd number of halfwords, the unpaired halfword is discarded and no word is stored for it. The next valid halfword starts a new pair as its upper half.
- R4: The write pointer advances by exactly one for each stored word. Memory writes during idle or partial-pair cycles leave every unread word intact, whatever `inData` carries.
- R5: A read request taken while `bufEmpty` is 0 is followed, two clock edges after the edge that samples it, by `rdValid` high for one cycle with the oldest unread word on `rdData`. `rdData` holds that value until the next read.
- R6: Words come out in the order they were stored. Both pointers wrap from entry 127 to entry 0 without disturbing that order.
- R7: At most 127 words are held. `bufFull` is 1 exactly when 127 words are unread. A word that completes while `bufFull` is 1 is dropped, and the stored words are not disturbed.
- R8: A read request while `bufEmpty` is 1 produces no `rdValid` pulse and does not move the read pointer.
- R9: `bufEmpty` is 1 exactly when no stored word is unread. It falls three clock edges after the edge that samples the second halfword of a pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Qualifies `inData` this cycle |
| inData | input | 16 | Incoming halfword |
| rdReq | input | 1 | Request for the next stored word |
| rdData | output | 32 | Registered read word |
| rdValid | output | 1 | One-cycle pulse marking new `rdData` |
| bufEmpty | output | 1 | No unread word stored |
| bufFull | output | 1 | 127 unread words stored; new words are dropped |

## Verification
The hardest state to reach from the ports is a full buffer whose write pointer has already wrapped past entry 127. In that state the parked slot sits right behind the oldest unread word, so a misplaced junk write or an off-by-one full test would overwrite live data. The stimulus first pushes and drains a table of words to move both pointers away from zero. It then streams 127 pairs back to back, plus one more that must be dropped, and drains everything, checking order and the flags. Orphan halfwords and idle cycles with toggling data are mixed in, to show that the always-on writes touch only the parked slot.

// File: rtl/hwpack_pkg.sv
package hwpack_pkg;

  // Strobes issued by the control unit to the datapath each cycle.
  typedef struct packed {
    logic loadHi;     // capture the upper halfword of a new pair
    logic loadPair;   // join the held upper half with the current halfword
    logic rdCapture;  // move the memory output into the read output register
  } ctrlStrobes_t;

  function automatic int unsigned addrBits(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/hwpack_ctrl.sv
module hwpack_ctrl
  import hwpack_pkg::*;
#(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned ADDR_W = addrBits(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              rdReq,
  output ctrlStrobes_t      strobes,
  output logic [ADDR_W-1:0] wrPtr,
  output logic [ADDR_W-1:0] rdPtr,
  output logic              rdValid,
  output logic              bufEmpty,
  output logic              bufFull
);

  logic haveHi;      // upper half of a pair is held
  logic pairValid;   // packed register holds a new word
  logic stageValid;  // staging register holds a new word
  logic rdLaunch;    // memory output register was loaded for a read
  logic commit;
  logic rdGo;

  // Pointer arithmetic relies on DEPTH being a power of two.
  localparam logic [ADDR_W-1:0] PTR_ONE = ADDR_W'(1);

  assign bufEmpty = (wrPtr == rdPtr);
  assign bufFull  = ((wrPtr + PTR_ONE) == rdPtr);

  assign commit = stageValid && !bufFull;
  assign rdGo   = rdReq && !bufEmpty;

  assign strobes.loadHi    = inValid && !haveHi;
  assign strobes.loadPair  = inValid && haveHi;
  assign strobes.rdCapture = rdLaunch;

  // Pair tracking: a drop of inValid throws away a half-built pair.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      haveHi     <= 1'b0;
      pairValid  <= 1'b0;
      stageValid <= 1'b0;
    end else begin
      haveHi     <= inValid ? !haveHi : 1'b0;
      pairValid  <= strobes.loadPair;
      stageValid <= pairValid;
    end
  end

  // Write pointer is the parked address; it moves only past a real word.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
    end else if (commit) begin
      wrPtr <= wrPtr + PTR_ONE;
    end
  end

  // Read pointer and read pipeline flags.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr    <= '0;
      rdLaunch <= 1'b0;
      rdValid  <= 1'b0;
    end else begin
      if (rdGo) begin
        rdPtr <= rdPtr + PTR_ONE;
      end
      rdLaunch <= rdGo;
      rdValid  <= rdLaunch;
    end
  end

  // R4
  wr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrPtr != $past(wrPtr)) |-> (wrPtr == ADDR_W'($past(wrPtr) + PTR_ONE)));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(bufFull) |-> (wrPtr == $past(wrPtr)));

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(bufEmpty) |-> (rdPtr == $past(rdPtr)));

  // R5
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> ($past(rdReq, 2) && !$past(bufEmpty, 2)));

  // R3
  pair_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!inValid) && inValid) |-> strobes.loadHi);

endmodule

// File: rtl/hwpack_dp.sv
module hwpack_dp
  import hwpack_pkg::*;
#(
  parameter int unsigned HALF_W = 16,
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned ADDR_W = addrBits(DEPTH),
  parameter int unsigned WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [HALF_W-1:0] inData,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WORD_W-1:0] rdData
);

  logic [HALF_W-1:0] hiReg;
  logic [WORD_W-1:0] packReg;   // first register of the pack path
  logic [WORD_W-1:0] stageReg;  // second register, drives memory data
  logic [WORD_W-1:0] memQ;      // memory output register
  logic [WORD_W-1:0] outReg;    // extra read output register
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiReg    <= '0;
      packReg  <= '0;
      stageReg <= '0;
    end else begin
      if (strobes.loadHi) begin
        hiReg <= inData;
      end
      if (strobes.loadPair) begin
        packReg <= {hiReg, inData};
      end
      stageReg <= packReg;
    end
  end

  // Write enable tied active: every cycle writes stageReg at the parked
  // or committing address, both of which come straight from registers.
  always_ff @(posedge clk) begin
    mem[wrAddr] <= stageReg;
  end

  always_ff @(posedge clk) begin
    memQ <= mem[rdAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outReg <= '0;
    end else if (strobes.rdCapture) begin
      outReg <= memQ;
    end
  end

  assign rdData = outReg;

  // R2
  pack_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobes.loadPair) && $past(strobes.loadHi, 2))
      |-> (packReg[WORD_W-1:HALF_W] == $past(inData, 2)));

  // R2
  stage_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.loadPair, 2) |-> (stageReg[HALF_W-1:0] == $past(inData, 2)));

endmodule

// File: rtl/hwpack_buf.sv
module hwpack_buf
  import hwpack_pkg::*;
#(
  parameter int unsigned HALF_W = 16,
  parameter int unsigned DEPTH  = 128
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [HALF_W-1:0]   inData,
  input  logic                rdReq,
  output logic [2*HALF_W-1:0] rdData,
  output logic                rdValid,
  output logic                bufEmpty,
  output logic                bufFull
);

  localparam int unsigned ADDR_W = addrBits(DEPTH);

  ctrlStrobes_t      strobes;
  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W-1:0] rdPtr;

  hwpack_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .rdReq    (rdReq),
    .strobes  (strobes),
    .wrPtr    (wrPtr),
    .rdPtr    (rdPtr),
    .rdValid  (rdValid),
    .bufEmpty (bufEmpty),
    .bufFull  (bufFull)
  );

  hwpack_dp #(.HALF_W(HALF_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .inData  (inData),
    .strobes (strobes),
    .wrAddr  (wrPtr),
    .rdAddr  (rdPtr),
    .rdData  (rdData)
  );

endmodule

// File: tb/tb_hwpack_buf.sv
module tb_hwpack_buf;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  // {orphanFirst, orphan, hi, lo, expected}
  localparam logic [80:0] VEC [NVEC] = '{
    {1'b0, 16'h0000, 16'h1234, 16'h5678, 32'h12345678},
    {1'b1, 16'hDEAD, 16'hAAAA, 16'h5555, 32'hAAAA5555},
    {1'b0, 16'h0000, 16'hFFFF, 16'h0000, 32'hFFFF0000},
    {1'b1, 16'hBEEF, 16'h0001, 16'h8000, 32'h00018000},
    {1'b0, 16'h0000, 16'h0000, 16'hFFFF, 32'h0000FFFF},
    {1'b1, 16'h7777, 16'hC3C3, 16'h3C3C, 32'hC3C33C3C},
    {1'b0, 16'h0000, 16'h9ABC, 16'hDEF0, 32'h9ABCDEF0},
    {1'b1, 16'h0F0F, 16'h2468, 16'h1357, 32'h24681357}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] inData = '0;
  logic        rdReq = 1'b0;
  logic [31:0] rdData;
  logic        rdValid;
  logic        bufEmpty;
  logic        bufFull;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hwpack_buf dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .rdReq(rdReq), .rdData(rdData), .rdValid(rdValid),
    .bufEmpty(bufEmpty), .bufFull(bufFull)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pushPair(input logic [15:0] hi, input logic [15:0] lo);
    @(negedge clk); inValid = 1'b1; inData = hi;
    @(negedge clk); inData = lo;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); inValid = 1'b0; inData = inData ^ 16'hA5C3;
    end
  endtask

  // Issues one request; returns with rdValid and rdData sampled.
  task automatic readOne(output logic [31:0] word, output logic vld, output logic early);
    @(negedge clk); rdReq = 1'b1;
    @(negedge clk); rdReq = 1'b0; early = rdValid;
    @(negedge clk); vld = rdValid; word = rdData;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] w;
    logic v, e;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 empty", 32'(bufEmpty), 32'd1);
    check("R1 full", 32'(bufFull), 32'd0);
    check("R1 rdValid", 32'(rdValid), 32'd0);
    check("R1 rdData", rdData, 32'd0);

    // R8 read while empty
    readOne(w, v, e);
    check("R8 no pulse", 32'(v), 32'd0);
    check("R8 still empty", 32'(bufEmpty), 32'd1);

    // Table walk: R2 order, R3 orphan discard, R5 latency, R9 empty
    for (int k = 0; k < NVEC; k++) begin
      if (VEC[k][80]) begin
        @(negedge clk); inValid = 1'b1; inData = VEC[k][79:64];
        @(negedge clk); inValid = 1'b0;
      end
      pushPair(VEC[k][63:48], VEC[k][47:32]);
      idle(2);
      check("R9 empty before commit", 32'(bufEmpty), 32'd1);
      idle(1);
      check("R9 not empty", 32'(bufEmpty), 32'd0);
      readOne(w, v, e);
      check("R5 not early", 32'(e), 32'd0);
      check("R5 valid", 32'(v), 32'd1);
      check(VEC[k][80] ? "R3 word" : "R2 word", w, VEC[k][31:0]);
      check("R3 single entry", 32'(bufEmpty), 32'd1);
    end

    // R5 rdData holds after pulse
    idle(2);
    check("R5 hold", rdData, VEC[NVEC-1][31:0]);
    check("R5 pulse ends", 32'(rdValid), 32'd0);

    // R4 junk writes with toggling data leave a stored word intact
    pushPair(16'hCAFE, 16'hF00D);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); inValid = (i % 3 == 0); inData = 16'(i * 16'h1111);
      @(negedge clk); inValid = 1'b0;
    end
    idle(4);
    readOne(w, v, e);
    check("R4 intact", w, 32'hCAFEF00D);
    check("R4 empty after", 32'(bufEmpty), 32'd1);

    // R7/R6 fill to capacity with wrapped pointers, then drain
    for (int i = 0; i < 127; i++) pushPair(16'(i), 16'(i) ^ 16'h5A5A);
    pushPair(16'hEEEE, 16'hEEEE);
    idle(5);
    check("R7 full", 32'(bufFull), 32'd1);
    for (int i = 0; i < 127; i++) begin
      readOne(w, v, e);
      if (i == 0) check("R7 full clears", 32'(bufFull), 32'd0);
      check("R6 order", w, {16'(i), 16'(i) ^ 16'h5A5A});
    end
    check("R7 dropped word absent", 32'(bufEmpty), 32'd1);

    // R6 continue after wrap
    pushPair(16'h0BAD, 16'hF00D);
    pushPair(16'h1357, 16'h2468);
    idle(4);
    readOne(w, v, e);
    check("R6 after wrap a", w, 32'h0BADF00D);
    readOne(w, v, e);
    check("R6 after wrap b", w, 32'h13572468);
    check("R9 empty end", 32'(bufEmpty), 32'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule